// File: doc/BRIEF.md
# Audio Automatic Gain Control

This block steers the gain code of a recording amplifier so that the mean magnitude of the digitized signal settles on a selected target level. Each accepted sample updates a running average of its absolute value. If that average is above the target, the gain is lowered by one 0.5 dB code per attack interval. If it is below the target, the gain is raised by one code per decay interval. Both intervals are a whole number of samples, derived from a time in milliseconds and the sample rate.

A noise gate stops quiet passages from being pumped up. When the average falls under the selected noise threshold, the gate raises a flag and lowers the gain by one code on every sample until the gain reaches 0 dB. The gate opens again only after the average has stayed at least 3 dB above the threshold for a run of consecutive samples. The ceiling on the gain is the programmed maximum. It is raised to a floor that grows with deeper noise thresholds, so that a sensitive gate cannot be combined with a tiny gain limit.

Samples arrive on a valid/ready stream. The block never applies back-pressure: `s_ready` is always high, and a sample is consumed in every cycle where `s_valid` is high. Cycles with `s_valid` low are ignored. The configuration inputs and the outputs are plain levels.

Top module: `agc_core`

## Requirements
- R1: `s_ready` is always 1. The level, the gate and the gain change only in cycles where `s_valid` is high. Data presented while `s_valid` is low has no effect on `gain`.
- R2: After reset, `gain` is 0, `noise_flag` is 0 and `sat_flag` is 0. The level estimate is an exponential mean of |sample| with weight 2^-AVG_SHIFT. For a constant magnitude it settles exactly on that magnitude.
- R3: When the gate is open, the level is below the target and `gain` is below the ceiling, `gain` rises by 1 every decay interval. The decay interval is (100 + 100·min(`cfg_decay`,4)) ms × FS_KHZ samples.
- R4: When the gate is open and the level is above the target, `gain` falls by 1 every attack interval, down to 0. The attack interval is (8 + 4·`cfg_attack`) ms × FS_KHZ samples. A gain that is above the ceiling also falls at the attack rate.
- R5: The ceiling is max(min(`cfg_max_gain`, GAIN_MAX), floor). The floor is code 0, 23, 43 or 63 for `cfg_noise` = 0, 1, 2 or 3. `gain` never steps upward past the ceiling.
- R6: `sat_flag` = gate open AND `gain` ≥ ceiling AND level < target.
- R7: `cfg_noise` 0..3 selects a threshold of −60, −70, −80 or −90 dB of full scale. A level below the threshold sets `noise_flag` on the next accepted sample. While the flag is set, `gain` drops by 1 per accepted sample until it reaches 0, and then stays at 0.
- R8: `noise_flag` clears only after the level has been at least 3 dB above the threshold for DEBOUNCE consecutive accepted samples. A level between the threshold and that release point keeps the flag set.
- R9: `cfg_target` 0..7 selects a target of −5.5, −8, −10.5, −13, −15.5, −18, −21 or −24 dB of full scale.
- R10: `gain` is in 0.5 dB units, with code 0 meaning 0 dB, and never exceeds GAIN_MAX (119 = 59.5 dB). It changes by at most one code per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Sample present |
| s_ready | output | 1 | Always 1; no back-pressure |
| s_data | input | W | Signed two's-complement sample |
| cfg_target | input | 3 | Target level select |
| cfg_attack | input | 2 | Attack time select |
| cfg_decay | input | 3 | Decay time select, values above 4 act as 4 |
| cfg_noise | input | 2 | Noise threshold select |
| cfg_max_gain | input | GW | Maximum gain code |
| gain | output | GW | Gain code, 0.5 dB per step |
| noise_flag | output | 1 | Noise gate closed |
| sat_flag | output | 1 | Gain held at ceiling while still too quiet |

## Verification
The assertions check the rules that must hold on every cycle:
- the gain moves by at most one code and only on an accepted sample;
- the gain never climbs past the ceiling;
- the gain ramps down one code per sample while the gate is closed;
- the gate closes on the sample after the level falls under the threshold;
- the gate opens only after a sample at or above the release level;
- the average stays within full scale.

The step intervals themselves, the choice among targets, thresholds and ceiling floors, and the hysteresis band can only be shown by the bench. It drives long runs of fixed-magnitude input and compares the final gain and flags with values worked out from the interval formulas.

// File: rtl/agc_pkg.sv
package agc_pkg;

  typedef enum logic [1:0] {DIR_HOLD = 2'd0, DIR_UP = 2'd1, DIR_DOWN = 2'd2} dir_e;

  // Target as a Q16 fraction of full scale
  function automatic logic [15:0] target_frac(input logic [2:0] sel);
    case (sel)
      3'd0: return 16'd34793;  // -5.5 dB
      3'd1: return 16'd26090;  // -8 dB
      3'd2: return 16'd19563;  // -10.5 dB
      3'd3: return 16'd14672;  // -13 dB
      3'd4: return 16'd11003;  // -15.5 dB
      3'd5: return 16'd8250;   // -18 dB
      3'd6: return 16'd5840;   // -21 dB
      default: return 16'd4135; // -24 dB
    endcase
  endfunction

  // Gate threshold as a Q24 fraction of full scale
  function automatic logic [15:0] gate_frac(input logic [1:0] sel);
    case (sel)
      2'd0: return 16'd16777;  // -60 dB
      2'd1: return 16'd5305;   // -70 dB
      2'd2: return 16'd1678;   // -80 dB
      default: return 16'd531; // -90 dB
    endcase
  endfunction

  // Release point, 3 dB above the threshold, Q24
  function automatic logic [15:0] release_frac(input logic [1:0] sel);
    case (sel)
      2'd0: return 16'd23730;
      2'd1: return 16'd7502;
      2'd2: return 16'd2373;
      default: return 16'd750;
    endcase
  endfunction

  // Lowest ceiling allowed for each threshold
  function automatic logic [6:0] ceil_floor(input logic [1:0] sel);
    case (sel)
      2'd0: return 7'd0;
      2'd1: return 7'd23;
      2'd2: return 7'd43;
      default: return 7'd63;
    endcase
  endfunction

endpackage

// File: rtl/agc_level.sv
module agc_level #(
  parameter int W  = 16,
  parameter int SH = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fire,
  input  logic signed [W-1:0] sample,
  output logic [W-1:0]        level
);
  localparam int AW = W + SH;
  localparam logic [W-1:0] FULL = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0]  mag;
  logic [AW-1:0] acc, acc_nx;

  always_comb begin
    mag    = sample[W-1] ? W'(-sample) : W'(sample);
    acc_nx = acc - (acc >> SH) + AW'(mag);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    acc <= '0;
    else if (fire) acc <= acc_nx;
  end

  assign level = acc[AW-1:SH];

  p_level_bounded_r2: assert property (@(posedge clk) disable iff (!rst_n)
    level <= FULL);

endmodule

// File: rtl/agc_gate.sv
module agc_gate #(
  parameter int W   = 16,
  parameter int DEB = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fire,
  input  logic [W-1:0] level,
  input  logic [W-1:0] thr,
  input  logic [W-1:0] rel,
  output logic         noise
);
  localparam int DW = $clog2(DEB + 1);

  logic [DW-1:0] deb;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      noise <= 1'b0;
      deb   <= '0;
    end else if (fire) begin
      if (!noise) begin
        if (level < thr) noise <= 1'b1;
        deb <= '0;
      end else if (level >= rel) begin
        if (deb == DW'(DEB - 1)) begin
          noise <= 1'b0;
          deb   <= '0;
        end else begin
          deb <= deb + 1'b1;
        end
      end else begin
        deb <= '0;
      end
    end
  end

  p_gate_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !noise && level < thr) |=> noise);

  p_gate_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(noise) |-> ($past(fire) && $past(level) >= $past(rel)));

  p_gate_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(noise));

endmodule

// File: rtl/agc_stepper.sv
module agc_stepper #(
  parameter int GW = 7,
  parameter int CW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic          noise,
  input  logic          loud,
  input  logic          quiet,
  input  logic [GW-1:0] ceil,
  input  logic [CW-1:0] attack_len,
  input  logic [CW-1:0] decay_len,
  output logic [GW-1:0] gain
);
  import agc_pkg::*;

  dir_e          dir, prev;
  logic [CW-1:0] cnt, cnt_nx, ivl;
  logic          step;

  always_comb begin
    if (noise)                                 dir = DIR_HOLD;
    else if ((loud && gain != '0) || gain > ceil) dir = DIR_DOWN;
    else if (quiet && gain < ceil)             dir = DIR_UP;
    else                                       dir = DIR_HOLD;
    ivl    = (dir == DIR_DOWN) ? attack_len : decay_len;
    cnt_nx = (dir == prev && dir != DIR_HOLD) ? cnt + 1'b1 : CW'(1);
    step   = (dir != DIR_HOLD) && (cnt_nx >= ivl);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gain <= '0;
      cnt  <= '0;
      prev <= DIR_HOLD;
    end else if (fire) begin
      prev <= dir;
      if (noise) begin
        if (gain != '0) gain <= gain - 1'b1;
        cnt <= '0;
      end else if (step) begin
        gain <= (dir == DIR_UP) ? gain + 1'b1 : gain - 1'b1;
        cnt  <= '0;
      end else begin
        cnt <= (dir == DIR_HOLD) ? '0 : cnt_nx;
      end
    end
  end

  p_gain_unit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (gain != $past(gain)) |->
      (gain == $past(gain) + 1'b1 || gain == $past(gain) - 1'b1));

  p_gain_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(gain));

  p_noise_ramp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && noise && gain != '0) |=> gain == $past(gain) - 1'b1);

  p_ceiling_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && gain >= ceil) |=> gain <= $past(gain));

endmodule

// File: rtl/agc_core.sv
module agc_core #(
  parameter int W         = 16,
  parameter int AVG_SHIFT = 4,
  parameter int FS_KHZ    = 48,
  parameter int DEBOUNCE  = 4,
  parameter int GAIN_MAX  = 119,
  localparam int GW       = $clog2(GAIN_MAX + 1),
  localparam int CW       = $clog2(500 * FS_KHZ + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic signed [W-1:0] s_data,
  input  logic [2:0]          cfg_target,
  input  logic [1:0]          cfg_attack,
  input  logic [2:0]          cfg_decay,
  input  logic [1:0]          cfg_noise,
  input  logic [GW-1:0]       cfg_max_gain,
  output logic [GW-1:0]       gain,
  output logic                noise_flag,
  output logic                sat_flag
);
  import agc_pkg::*;

  logic          fire, loud, quiet;
  logic [W-1:0]  level, target, thr, rel;
  logic [W+15:0] tgt_wide, thr_wide, rel_wide;
  logic [GW-1:0] cap, floor_c, ceil;
  logic [2:0]    dsel;
  logic [31:0]   att32, dec32;
  logic [CW-1:0] attack_len, decay_len;

  assign s_ready = 1'b1;
  assign fire    = s_valid;

  always_comb begin
    tgt_wide   = {{W{1'b0}}, target_frac(cfg_target)} << (W - 1);
    thr_wide   = {{W{1'b0}}, gate_frac(cfg_noise)} << (W - 1);
    rel_wide   = {{W{1'b0}}, release_frac(cfg_noise)} << (W - 1);
    target     = tgt_wide[W+15:16];
    thr        = W'(thr_wide >> 24);
    rel        = W'(rel_wide >> 24);
    cap        = (cfg_max_gain > GW'(GAIN_MAX)) ? GW'(GAIN_MAX) : cfg_max_gain;
    floor_c    = GW'(ceil_floor(cfg_noise));
    ceil       = (cap > floor_c) ? cap : floor_c;
    dsel       = (cfg_decay > 3'd4) ? 3'd4 : cfg_decay;
    att32      = (32'd8 + 32'd4 * 32'(cfg_attack)) * 32'(FS_KHZ);
    dec32      = (32'd100 + 32'd100 * 32'(dsel)) * 32'(FS_KHZ);
    attack_len = CW'(att32);
    decay_len  = CW'(dec32);
    loud       = level > target;
    quiet      = level < target;
    sat_flag   = !noise_flag && (gain >= ceil) && quiet;
  end

  agc_level #(.W(W), .SH(AVG_SHIFT)) u_level (
    .clk(clk), .rst_n(rst_n), .fire(fire), .sample(s_data), .level(level)
  );

  agc_gate #(.W(W), .DEB(DEBOUNCE)) u_gate (
    .clk(clk), .rst_n(rst_n), .fire(fire), .level(level),
    .thr(thr), .rel(rel), .noise(noise_flag)
  );

  agc_stepper #(.GW(GW), .CW(CW)) u_step (
    .clk(clk), .rst_n(rst_n), .fire(fire), .noise(noise_flag),
    .loud(loud), .quiet(quiet), .ceil(ceil),
    .attack_len(attack_len), .decay_len(decay_len), .gain(gain)
  );

  p_sat_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sat_flag |-> (!noise_flag && gain != '0 || ceil == '0));

endmodule

// File: tb/agc_core_test.sv
module agc_core_test;
  localparam int W  = 16;
  localparam int GW = 7;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                s_valid = 1'b0;
  logic                s_ready;
  logic signed [W-1:0] s_data = '0;
  logic [2:0]          cfg_target = 3'd0;
  logic [1:0]          cfg_attack = 2'd0;
  logic [2:0]          cfg_decay = 3'd0;
  logic [1:0]          cfg_noise = 2'd0;
  logic [GW-1:0]       cfg_max_gain = 7'd119;
  logic [GW-1:0]       gain;
  logic                noise_flag, sat_flag;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  agc_core #(.W(W), .AVG_SHIFT(4), .FS_KHZ(1), .DEBOUNCE(4), .GAIN_MAX(119)) uut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .cfg_target(cfg_target), .cfg_attack(cfg_attack), .cfg_decay(cfg_decay),
    .cfg_noise(cfg_noise), .cfg_max_gain(cfg_max_gain),
    .gain(gain), .noise_flag(noise_flag), .sat_flag(sat_flag)
  );

  task automatic chk_eq(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d..%0d", tag, act, lo, hi);
    end
  endtask

  // n accepted samples of alternating sign and fixed magnitude
  task automatic feed(input int mag, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      s_valid = 1'b1;
      s_data  = (i % 2 == 0) ? W'(mag) : W'(-mag);
    end
    @(negedge clk);
    s_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_eq("R2 reset gain", int'(gain), 0);
    chk_eq("R2 reset noise", int'(noise_flag), 0);
    chk_eq("R2 reset sat", int'(sat_flag), 0);
    chk_eq("R1 ready", int'(s_ready), 1);
  endtask

  task automatic t_decay_rise;
    feed(1000, 1000);  // ~9 steps at 100 samples each
    chk_rng("R3 decay rise", int'(gain), 8, 10);
    chk_eq("R3 gate open", int'(noise_flag), 0);
    chk_eq("R6 sat clear below ceiling", int'(sat_flag), 0);
  endtask

  task automatic t_ceiling;
    cfg_max_gain = 7'd5;
    feed(1000, 200);
    chk_eq("R5 gain pulled to ceiling", int'(gain), 5);
    chk_eq("R6 sat at ceiling", int'(sat_flag), 1);
    cfg_noise = 2'd1;  // floor 23 overrides max of 5
    feed(1000, 2500);
    chk_eq("R5 floor ceiling", int'(gain), 23);
    chk_eq("R6 sat at floor", int'(sat_flag), 1);
  endtask

  task automatic t_idle;
    @(negedge clk);
    s_data = W'(30000);
    repeat (500) @(negedge clk);
    chk_eq("R1 idle gain", int'(gain), 23);
    chk_eq("R1 ready while idle", int'(s_ready), 1);
  endtask

  task automatic t_attack;
    cfg_max_gain = 7'd119;
    feed(30000, 100);  // ~13 samples to cross, then one step per 8
    chk_rng("R4 attack fall", int'(gain), 11, 14);
    chk_eq("R6 sat clear when loud", int'(sat_flag), 0);
    feed(30000, 200);
    chk_eq("R4 attack floor", int'(gain), 0);
  endtask

  task automatic t_targets;
    cfg_target = 3'd7;
    feed(1500, 1000);
    chk_rng("R9 low target rise", int'(gain), 8, 10);
    feed(3000, 150);
    chk_eq("R9 above low target falls", int'(gain), 0);
    cfg_target = 3'd0;
    feed(3000, 500);
    chk_rng("R9 high target rises", int'(gain), 4, 5);
    cfg_decay = 3'd4;  // 500 samples per step
    feed(3000, 1000);
    chk_rng("R3 slow decay", int'(gain), 6, 7);
    cfg_decay = 3'd0;
    cfg_attack = 2'd3;  // 20 samples per step
    feed(30000, 100);
    chk_rng("R4 slow attack", int'(gain), 2, 4);
    cfg_attack = 2'd0;
    feed(30000, 200);
    chk_eq("R4 back to zero", int'(gain), 0);
  endtask

  task automatic t_noise;
    cfg_noise = 2'd0;  // thr 32, release 46
    feed(1000, 2000);
    chk_rng("R3 gain before gate", int'(gain), 18, 20);
    feed(0, 100);
    chk_eq("R7 gate ramps gain to 0", int'(gain), 0);
    chk_eq("R7 noise flag", int'(noise_flag), 1);
    chk_eq("R6 sat masked by gate", int'(sat_flag), 0);
  endtask

  task automatic t_hyst;
    feed(40, 300);
    chk_eq("R8 inside band stays gated", int'(noise_flag), 1);
    chk_eq("R7 gain held at 0", int'(gain), 0);
    feed(60, 300);
    chk_eq("R8 release above band", int'(noise_flag), 0);
  endtask

  initial begin
    t_reset();
    t_decay_rise();
    t_ceiling();
    t_idle();
    t_attack();
    t_targets();
    t_noise();
    t_hyst();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule